// File: doc/BRIEF.md
# Converter Serial Register Port

This block is the host-facing serial port of a sigma-delta converter. A host drives an active-low chip select, a serial clock that idles high, and a data input. The block drives one data output that serves two purposes: while a register is being read it carries the register bits, and at all other times it carries an active-low "result ready" flag. Every access starts with an 8-bit command byte. The command byte says whether the next word is read or written and which register it targets. A 24-bit word then follows, MSB first. Two 24-bit configuration registers can be written and read back. The conversion result register can only be read.

The conversion engine is represented by a one-cycle result strobe carrying a 24-bit offset-binary word, plus a one-cycle early-warning strobe that it raises just before it updates the result. A continuous-read mode lets the host collect each new result with 24 clocks and no command byte. An active-low filter synchronisation input holds the ready flag released and blocks incoming results, without disturbing the serial logic.

The port runs on a fast system clock. The chip select, serial clock and data input pass through a two-flop synchroniser before use. Chip select may stay low for the whole session (3-wire use) or may frame each access.

Top module: `adc_serial_port`

## Requirements
- R1: The output enable is high exactly when chip select is low, delayed by three system clock edges: the pin level sampled at one edge appears on `sdo_oe_o` after the third edge, counting that sampling edge.
- R2: The command byte has this layout: bit 7 must be 0, bit 6 is 1 for read and 0 for write, bits 5:3 are the register address, bit 2 requests continuous read, and bits 1:0 are ignored. A byte with bit 7 set is dropped, and the port waits for a fresh command byte.
- R3: After a write command, 24 bits are shifted in MSB first on rising SCLK edges. They are stored in configuration A (address 1) or configuration B (address 2). A write to any other address, including the result register at address 3, changes nothing.
- R4: After a read command, the addressed 24-bit word is sent MSB first. Each bit is driven after a falling SCLK edge and is valid at the following rising edge. Addresses 0 and 4 to 7 read as zero.
- R5: A result strobe while sync is high latches the word and pulls the ready flag low. Between transfers, the output line shows the ready flag.
- R6: A completed 24-bit read of the result register (address 3) releases the ready flag high.
- R7: If the result has not been read, the early-warning strobe releases the ready flag high. The stored result stays readable.
- R8: Outside continuous read, the same result can be read again while the ready flag is high.
- R9: Command 0x5C (read, address 3, bit 2 set) enters continuous read. Each time the flag is low, 24 SCLK cycles shift out the result with no command byte, and the flag is then released. While the flag is high, SCLK edges are ignored and the line stays high, so each result is delivered only once.
- R10: In continuous read, if the first 8 DIN bits of a result transfer form 0x58 (read, address 3, bit 2 clear), the port returns to command mode after that word.
- R11: While sync is low, the ready flag is held high and result strobes are dropped. Serial register accesses keep working.
- R12: Chip select high aborts any partial transfer, and SCLK edges are ignored until chip select goes low again. The port then waits for a command byte, or stays in continuous read if that mode was active. Back-to-back accesses work with chip select held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csn_i | input | 1 | Chip select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, idles high, asynchronous |
| sdi_i | input | 1 | Serial data in, sampled on rising SCLK |
| sync_n_i | input | 1 | Filter sync, active low, synchronous to clk |
| res_valid_i | input | 1 | One-cycle strobe: new conversion result |
| res_word_i | input | 24 | Conversion result, offset binary |
| upd_warn_i | input | 1 | One-cycle strobe: result update imminent |
| sdo_o | output | 1 | Serial data out / active-low ready flag |
| sdo_oe_o | output | 1 | Output enable for `sdo_o` |
| cfg_a_o | output | 24 | Configuration register A |
| cfg_b_o | output | 24 | Configuration register B |

## Verification
A pin edge on SCLK is seen by the engine at the third system clock edge and reaches `sdo_o` at the fourth. A result or warning strobe reaches the line after two edges. Chip select reaches the output enable after three edges. The bench therefore holds each SCLK half period for eight clocks and samples the line at the end of the low half, so each read bit has settled before it is taken. It waits at least four clocks after each strobe or transfer before checking the ready flag. The output enable is compared on every clock against a three-sample history of the chip select the bench drove.

// File: rtl/sps_pkg.sv
`timescale 1ns/1ps
package sps_pkg;
  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD, PH_CR} phase_t;

  localparam int CMD_W      = 8;
  localparam int CB_GUARD   = 7;
  localparam int CB_RNW     = 6;
  localparam int CB_ADDR_HI = 5;
  localparam int CB_ADDR_LO = 3;
  localparam int CB_CREAD   = 2;

  localparam logic [2:0] RA_CFG_A = 3'd1;
  localparam logic [2:0] RA_CFG_B = 3'd2;
  localparam logic [2:0] RA_DATA  = 3'd3;
endpackage

// File: rtl/sps_sync.sv
`timescale 1ns/1ps
// Multi-bit level synchroniser for asynchronous pins.
module sps_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= {STAGES{RST_VAL}};
    end else begin
      st[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign lvl_o = st[STAGES-1];
endmodule

// File: rtl/sps_edge.sv
`timescale 1ns/1ps
// Edge detector on an already synchronised level.
module sps_edge #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/sps_ready.sv
`timescale 1ns/1ps
// Result latch and active-low ready flag.
module sps_ready #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_n_i,
  input  logic              res_valid_i,
  input  logic [WORD_W-1:0] res_word_i,
  input  logic              upd_warn_i,
  input  logic              rd_done_i,
  output logic              rdy_n_o,
  output logic [WORD_W-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_n_o <= 1'b1;
      data_o  <= '0;
    end else if (!sync_n_i) begin
      rdy_n_o <= 1'b1;
    end else if (res_valid_i) begin
      data_o  <= res_word_i;
      rdy_n_o <= 1'b0;
    end else if (upd_warn_i || rd_done_i) begin
      rdy_n_o <= 1'b1;
    end
  end

  // R11: sync low keeps the flag released
  a_r11_sync_holds_ready: assert property (@(posedge clk) disable iff (rst)
    !sync_n_i |=> rdy_n_o);

  // R5: a result arms the flag and is latched
  a_r5_result_arms: assert property (@(posedge clk) disable iff (rst)
    (sync_n_i && res_valid_i) |=> (!rdy_n_o && data_o == $past(res_word_i)));

  // R6 / R7: read completion or early warning releases the flag
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    (sync_n_i && !res_valid_i && (upd_warn_i || rd_done_i)) |=> rdy_n_o);
endmodule

// File: rtl/sps_engine.sv
`timescale 1ns/1ps
// Command decode, shift registers and configuration storage.
module sps_engine import sps_pkg::*; #(
  parameter int                WORD_W    = 24,
  parameter logic [WORD_W-1:0] CFG_A_RST = '0,
  parameter logic [WORD_W-1:0] CFG_B_RST = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              sdi_i,
  input  logic              rdy_n_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              sdo_bit_o,
  output logic              rd_active_o,
  output logic              rd_done_o,
  output logic [WORD_W-1:0] cfg_a_o,
  output logic [WORD_W-1:0] cfg_b_o
);
  localparam int             CNT_W     = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] LAST_CMD  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] CMD_BITS  = CNT_W'(CMD_W);

  phase_t              phase_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [CMD_W-1:0]    cmd_q;
  logic [WORD_W-2:0]   in_q;
  logic [WORD_W-1:0]   out_q, cfg_a_q, cfg_b_q, rd_word;
  logic [2:0]          addr_q;
  logic                cread_q, sdo_q, done_q;

  logic [CMD_W-1:0]    cmd_next;
  logic [WORD_W-1:0]   in_next;
  logic [2:0]          cmd_addr;
  logic                exit_hit;

  assign cmd_next = {cmd_q[CMD_W-2:0], sdi_i};
  assign in_next  = {in_q, sdi_i};
  assign cmd_addr = cmd_next[CB_ADDR_HI:CB_ADDR_LO];
  assign exit_hit = !cmd_q[CB_GUARD] && cmd_q[CB_RNW] && !cmd_q[CB_CREAD]
                    && (cmd_q[CB_ADDR_HI:CB_ADDR_LO] == RA_DATA);

  always_comb begin
    case (cmd_addr)
      RA_CFG_A: rd_word = cfg_a_q;
      RA_CFG_B: rd_word = cfg_b_q;
      RA_DATA:  rd_word = data_i;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      cmd_q   <= '0;
      in_q    <= '0;
      out_q   <= '0;
      cfg_a_q <= CFG_A_RST;
      cfg_b_q <= CFG_B_RST;
      addr_q  <= '0;
      cread_q <= 1'b0;
      sdo_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!cs_act_i) begin
        phase_q <= cread_q ? PH_CR : PH_CMD;
        cnt_q   <= '0;
      end else begin
        case (phase_q)
          PH_CMD: if (sck_rise_i) begin
            cmd_q <= cmd_next;
            if (cnt_q == LAST_CMD) begin
              cnt_q  <= '0;
              addr_q <= cmd_addr;
              if (!cmd_next[CB_GUARD]) begin
                if (!cmd_next[CB_RNW]) begin
                  phase_q <= PH_WR;
                end else if (cmd_addr == RA_DATA && cmd_next[CB_CREAD]) begin
                  cread_q <= 1'b1;
                  phase_q <= PH_CR;
                end else begin
                  out_q   <= rd_word;
                  phase_q <= PH_RD;
                end
              end
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          PH_WR: if (sck_rise_i) begin
            in_q <= in_next[WORD_W-2:0];
            if (cnt_q == LAST_WORD) begin
              cnt_q   <= '0;
              phase_q <= PH_CMD;
              if (addr_q == RA_CFG_A)      cfg_a_q <= in_next;
              else if (addr_q == RA_CFG_B) cfg_b_q <= in_next;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          PH_RD: begin
            if (sck_fall_i) begin
              sdo_q <= out_q[WORD_W-1];
              out_q <= out_q << 1;
            end
            if (sck_rise_i) begin
              if (cread_q && cnt_q < CMD_BITS) cmd_q <= cmd_next;
              if (cnt_q == LAST_WORD) begin
                cnt_q  <= '0;
                done_q <= (addr_q == RA_DATA);
                if (cread_q && !exit_hit) begin
                  phase_q <= PH_CR;
                end else begin
                  phase_q <= PH_CMD;
                  cread_q <= 1'b0;
                end
              end else begin
                cnt_q <= cnt_q + CNT_W'(1);
              end
            end
          end
          PH_CR: if (sck_fall_i && !rdy_n_i) begin
            sdo_q   <= data_i[WORD_W-1];
            out_q   <= data_i << 1;
            cmd_q   <= '0;
            cnt_q   <= '0;
            addr_q  <= RA_DATA;
            phase_q <= PH_RD;
          end
          default: phase_q <= PH_CMD;
        endcase
      end
    end
  end

  assign sdo_bit_o   = sdo_q;
  assign rd_active_o = (phase_q == PH_RD);
  assign rd_done_o   = done_q;
  assign cfg_a_o     = cfg_a_q;
  assign cfg_b_o     = cfg_b_q;

  // R12: deselect clears the bit counter and leaves no transfer open
  a_r12_cs_idle: assert property (@(posedge clk) disable iff (rst)
    !cs_act_i |=> (cnt_q == '0 && phase_q != PH_RD && phase_q != PH_WR));

  // R9: with the flag released, continuous read never starts a transfer
  a_r9_once_only: assert property (@(posedge clk) disable iff (rst)
    (cs_act_i && phase_q == PH_CR && rdy_n_i) |=> (phase_q != PH_RD));

  // R3: configuration changes only on the last bit of a write
  a_r3_cfg_stable: assert property (@(posedge clk) disable iff (rst)
    !(cs_act_i && phase_q == PH_WR && sck_rise_i) |=> ($stable(cfg_a_q) && $stable(cfg_b_q)));
endmodule

// File: rtl/adc_serial_port.sv
`timescale 1ns/1ps
module adc_serial_port import sps_pkg::*; #(
  parameter int                WORD_W      = 24,
  parameter int                SYNC_STAGES = 2,
  parameter logic [WORD_W-1:0] CFG_A_RST   = '0,
  parameter logic [WORD_W-1:0] CFG_B_RST   = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              sync_n_i,
  input  logic              res_valid_i,
  input  logic [WORD_W-1:0] res_word_i,
  input  logic              upd_warn_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [WORD_W-1:0] cfg_a_o,
  output logic [WORD_W-1:0] cfg_b_o
);
  localparam int PIN_W = 3;

  logic [PIN_W-1:0]  pin_lvl;
  logic              cs_act, sck_rise, sck_fall;
  logic              sdo_bit, rd_active, rd_done, rdy_n;
  logic [WORD_W-1:0] data_word;

  sps_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst(rst), .d_i({csn_i, sclk_i, sdi_i}), .lvl_o(pin_lvl));

  sps_edge #(.RST_VAL(1'b1)) u_sck_edge (
    .clk(clk), .rst(rst), .lvl_i(pin_lvl[1]), .rise_o(sck_rise), .fall_o(sck_fall));

  assign cs_act = ~pin_lvl[2];

  sps_ready #(.WORD_W(WORD_W)) u_ready (
    .clk(clk), .rst(rst), .sync_n_i(sync_n_i), .res_valid_i(res_valid_i),
    .res_word_i(res_word_i), .upd_warn_i(upd_warn_i), .rd_done_i(rd_done),
    .rdy_n_o(rdy_n), .data_o(data_word));

  sps_engine #(.WORD_W(WORD_W), .CFG_A_RST(CFG_A_RST), .CFG_B_RST(CFG_B_RST)) u_engine (
    .clk(clk), .rst(rst), .cs_act_i(cs_act), .sck_rise_i(sck_rise), .sck_fall_i(sck_fall),
    .sdi_i(pin_lvl[0]), .rdy_n_i(rdy_n), .data_i(data_word),
    .sdo_bit_o(sdo_bit), .rd_active_o(rd_active), .rd_done_o(rd_done),
    .cfg_a_o(cfg_a_o), .cfg_b_o(cfg_b_o));

  // Registered line driver: read bit during a read, ready flag otherwise.
  always_ff @(posedge clk) begin
    if (rst) begin
      sdo_o    <= 1'b1;
      sdo_oe_o <= 1'b0;
    end else begin
      sdo_o    <= rd_active ? sdo_bit : rdy_n;
      sdo_oe_o <= cs_act;
    end
  end

  // R5: outside a read, the line tracks the ready flag one cycle later
  a_r5_line_shows_ready: assert property (@(posedge clk) disable iff (rst)
    !rd_active |=> (sdo_o == $past(rdy_n)));
endmodule

// File: tb/adc_serial_port_test.sv
`timescale 1ns/1ps
module adc_serial_port_test;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csn = 1'b1, sclk = 1'b1, sdi = 1'b0, sync_n = 1'b1;
  logic        res_valid = 1'b0, upd_warn = 1'b0;
  logic [23:0] res_word = '0;
  logic        sdo_o, sdo_oe_o;
  logic [23:0] cfg_a_o, cfg_b_o;

  int checks = 0;
  int errors = 0;
  logic [2:0] csh = 3'b111;

  // behavioural model state
  logic [23:0] m_a = '0, m_b = '0, m_data = '0;
  logic        m_rdy_n = 1'b1;

  always #2.5 clk = ~clk;

  adc_serial_port uut (
    .clk(clk), .rst(rst), .csn_i(csn), .sclk_i(sclk), .sdi_i(sdi), .sync_n_i(sync_n),
    .res_valid_i(res_valid), .res_word_i(res_word), .upd_warn_i(upd_warn),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .cfg_a_o(cfg_a_o), .cfg_b_o(cfg_b_o));

  // R1: per-clock output enable against a three-sample chip select history
  always @(posedge clk) csh <= {csh[1:0], csn};
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (sdo_oe_o !== ~csh[2]) begin
        errors++;
        $display("FAIL R1 output enable actual=%0b expected=%0b", sdo_oe_o, ~csh[2]);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift(input logic [31:0] din, input int n, output logic [31:0] dout);
    dout = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b0;
      sdi  = din[i];
      wait_clk(HALF);
      dout[i] = sdo_o;
      sclk = 1'b1;
      wait_clk(HALF);
    end
    wait_clk(4);
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [23:0] v);
    logic [31:0] d;
    shift({24'b0, 2'b00, a, 3'b000}, 8, d);
    shift({8'b0, v}, 24, d);
    if (a == 3'd1) m_a = v;
    if (a == 3'd2) m_b = v;
  endtask

  task automatic read_reg(input logic [2:0] a, output logic [23:0] v);
    logic [31:0] d;
    shift({24'b0, 2'b01, a, 3'b000}, 8, d);
    shift(32'b0, 24, d);
    v = d[23:0];
    if (a == 3'd3) m_rdy_n = 1'b1;
  endtask

  task automatic pulse_result(input logic [23:0] v);
    res_word  = v;
    res_valid = 1'b1;
    wait_clk(1);
    res_valid = 1'b0;
    wait_clk(4);
    if (sync_n) begin
      m_data  = v;
      m_rdy_n = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] v;
    logic [31:0] d;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    chk("R1 reset enable", sdo_oe_o, 0);
    chk("R5 reset line", sdo_o, 1);
    chk("R3 reset cfg A", cfg_a_o, 0);
    chk("R3 reset cfg B", cfg_b_o, 0);

    csn = 1'b0;
    wait_clk(4);
    chk("R1 enable after select", sdo_oe_o, 1);
    chk("R5 idle ready high", sdo_o, m_rdy_n);

    write_reg(3'd1, 24'hA5C396);
    chk("R3 write cfg A", cfg_a_o, m_a);
    write_reg(3'd2, 24'h123456);
    chk("R3 write cfg B", cfg_b_o, m_b);
    write_reg(3'd4, 24'hFFFFFF);
    chk("R3 unmapped write A", cfg_a_o, m_a);
    chk("R3 unmapped write B", cfg_b_o, m_b);

    read_reg(3'd1, v); chk("R4 read cfg A", v, m_a);
    read_reg(3'd2, v); chk("R4 read cfg B", v, m_b);
    read_reg(3'd6, v); chk("R4 read unmapped", v, 0);

    shift(32'h88, 8, d);
    chk("R2 guard byte no write", cfg_a_o, m_a);
    read_reg(3'd1, v); chk("R2 command state after guard byte", v, m_a);

    pulse_result(24'h800001);
    chk("R5 ready low after result", sdo_o, m_rdy_n);
    read_reg(3'd3, v); chk("R5 result word", v, 24'h800001);
    chk("R6 ready high after read", sdo_o, m_rdy_n);
    read_reg(3'd3, v); chk("R8 reread same result", v, m_data);
    chk("R8 ready stays high", sdo_o, 1);

    write_reg(3'd3, 24'h000000);
    read_reg(3'd3, v); chk("R3 result not writable", v, m_data);

    pulse_result(24'h7FFFFF);
    chk("R5 ready low second result", sdo_o, 0);
    upd_warn = 1'b1; wait_clk(1); upd_warn = 1'b0; wait_clk(4);
    m_rdy_n = 1'b1;
    chk("R7 warning releases ready", sdo_o, m_rdy_n);
    read_reg(3'd3, v); chk("R7 result kept", v, 24'h7FFFFF);

    pulse_result(24'h222222);
    chk("R11 ready low before sync", sdo_o, 0);
    sync_n = 1'b0; wait_clk(4);
    m_rdy_n = 1'b1;
    chk("R11 sync forces ready high", sdo_o, m_rdy_n);
    pulse_result(24'h333333);
    chk("R11 result ignored in sync", sdo_o, 1);
    write_reg(3'd2, 24'h0F0F0F);
    chk("R11 serial write during sync", cfg_b_o, m_b);
    sync_n = 1'b1; wait_clk(4);
    chk("R11 ready still high after sync", sdo_o, 1);
    read_reg(3'd3, v); chk("R11 latched result kept", v, 24'h222222);

    shift(32'h4, 4, d);
    csn = 1'b1; wait_clk(4);
    shift(32'hFF, 8, d);
    chk("R12 edges ignored while deselected", cfg_a_o, m_a);
    csn = 1'b0; wait_clk(4);
    read_reg(3'd1, v); chk("R12 read after abort", v, m_a);
    read_reg(3'd2, v); chk("R12 back-to-back 3-wire read", v, m_b);

    shift(32'h5C, 8, d);
    chk("R9 idle line high in continuous read", sdo_o, 1);
    shift(32'h0, 24, d);
    chk("R9 edges ignored while ready high", d, 32'hFFFFFF);
    pulse_result(24'hC0FFEE);
    chk("R9 ready low in continuous read", sdo_o, 0);
    shift(32'h0, 24, d);
    m_rdy_n = 1'b1;
    chk("R9 word without command", d, 32'hC0FFEE);
    chk("R9 ready high after word", sdo_o, m_rdy_n);
    shift(32'h0, 24, d);
    chk("R9 result only once", d, 32'hFFFFFF);

    pulse_result(24'h0ABCDE);
    shift({8'b0, 8'h58, 16'h0}, 24, d);
    m_rdy_n = 1'b1;
    chk("R10 word on exit transfer", d, 32'h0ABCDE);
    read_reg(3'd1, v); chk("R10 command mode after exit", v, m_a);
    pulse_result(24'h055555);
    chk("R10 ready low after exit", sdo_o, 0);
    read_reg(3'd3, v); chk("R10 normal data read", v, 24'h055555);
    chk("R6 ready high after normal read", sdo_o, m_rdy_n);

    wait_clk(10);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule